// File: doc/BRIEF.md
# Vertical Blanking Data Gate

This block sits in the data path of a video encoder. For each incoming 4:2:2 sample it decides whether the sample passes through unchanged or is replaced by the blanking level. It decides from the current line number, the selected video standard, the timing mode and a small set of control bits. Lines after the vertical blanking interval always pass. Inside the interval, only a window of lines that depends on the standard may carry ancillary data, and only when the controls allow it.

The output is registered once. It carries the gated sample, a copy of the luma/chroma phase flag and a flag that marks blanked samples. Line counting and the generation of copy-protection waveforms are done elsewhere. The gate only lets the copy-protection line through when its override applies.

Top module: `vbi_gate`

## Requirements
- R1: With `std_sel`=0 (525-line progressive), lines 13 to 42 pass when enabled, and lines 1 to 12 are blanked.
- R2: With `std_sel`=1 (625-line progressive), lines 6 to 43 pass when enabled, and lines 1 to 5 are blanked.
- R3: With `std_sel`=2 (SD 525-line interlaced), lines 10 to 20 pass when enabled, and lines 1 to 9 are blanked.
- R4: With `std_sel`=3 (SD 625-line interlaced), lines 7 to 22 pass when enabled, and lines 1 to 6 are blanked.
- R5: Any line numbered above the last line of the standard's pass window passes, whatever the control inputs are.
- R6: When the applicable enable bit is low, every line up to the end of the window is blanked, in every timing mode, unless R9 applies.
- R7: In master mode (`tmode`=0) and in slave mode 0 (`tmode`=1), an enabled window line passes without further conditions.
- R8: In slave modes 1/2 (`tmode`=2 or 3), a window line passes only when `blk_ctl_en` is 1, and is blanked otherwise.
- R9: With `cgms_en`=1 and `cgms_line`=1 on a blanking-interval line while the applicable enable is low, the sample passes.
- R10: A blanked sample is driven to 0x10 when `in_luma`=1 and to 0x80 when `in_luma`=0, each shifted left by DW-8, and `out_blank` is 1.
- R11: The output is registered with a latency of one clock, and a passed sample reaches the output unchanged with `out_blank`=0.
- R12: Standards 0 and 1 use `vbi_en_hd`, and standards 2 and 3 use `vbi_en_sd`. The other enable bit has no effect.
- R13: While `rst` is high, the outputs are `out_blank`=1, `out_luma`=1 and `out_data`=0x10 (scaled as in R10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 2 | Standard: 0 525p, 1 625p, 2 SD 525i, 3 SD 625i |
| tmode | input | 2 | Timing mode: 0 master, 1 slave 0, 2/3 slave 1/2 |
| vbi_en_hd | input | 1 | Ancillary pass enable for progressive standards |
| vbi_en_sd | input | 1 | Ancillary pass enable for SD standards |
| blk_ctl_en | input | 1 | Blank-control enable needed in slave modes 1/2 |
| cgms_en | input | 1 | Copy-protection line enable |
| cgms_line | input | 1 | Current line carries the copy-protection data |
| line_num | input | LINE_W | Current line number, 1-based |
| in_luma | input | 1 | 1 when `in_data` is a luma sample |
| in_data | input | DW | Incoming sample |
| out_data | output | DW | Gated sample |
| out_luma | output | 1 | Registered luma flag |
| out_blank | output | 1 | 1 when `out_data` holds a blanking level |

## Verification
On every cycle the assertions check the one-cycle relation between the pass decision and the output. They check that a blanked sample carries the right level for its phase, that lines after the window always pass, and that a disabled interval is blanked. They also check that slave modes 1/2 blank without the blank-control bit and that the copy-protection override passes. The bench's scenarios are needed to show the exact boundary lines of each standard's window, that the unused enable bit has no effect, the reset values, and that the output holds its old value until the clock edge.

// File: rtl/vbg_pkg.sv
package vbg_pkg;

    typedef enum logic [1:0] {
        STD_525P = 2'd0,
        STD_625P = 2'd1,
        STD_SD525 = 2'd2,
        STD_SD625 = 2'd3
    } vstd_e;

    typedef enum logic [1:0] {
        TM_MASTER  = 2'd0,
        TM_SLAVE0  = 2'd1,
        TM_SLAVE12 = 2'd2,
        TM_SLAVE12B = 2'd3
    } tmode_e;

    typedef struct packed {
        logic vbi_en_hd;
        logic vbi_en_sd;
        logic blk_ctl_en;
        logic cgms_en;
        logic cgms_line;
    } gate_ctl_t;

    localparam int WIN_W = 6;

    function automatic logic [WIN_W-1:0] win_lo(vstd_e s);
        case (s)
            STD_525P:  return 6'd13;
            STD_625P:  return 6'd6;
            STD_SD525: return 6'd10;
            default:   return 6'd7;
        endcase
    endfunction

    function automatic logic [WIN_W-1:0] win_hi(vstd_e s);
        case (s)
            STD_525P:  return 6'd42;
            STD_625P:  return 6'd43;
            STD_SD525: return 6'd20;
            default:   return 6'd22;
        endcase
    endfunction

    function automatic logic std_is_prog(vstd_e s);
        return (s == STD_525P) || (s == STD_625P);
    endfunction

endpackage

// File: rtl/vbg_window.sv
module vbg_window
    import vbg_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  vstd_e             std_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              in_vbi_o,
    output logic              in_win_o
);
    localparam int PADW = LINE_W - WIN_W;

    logic [LINE_W-1:0] lo_ext;
    logic [LINE_W-1:0] hi_ext;

    always_comb begin
        lo_ext   = {{PADW{1'b0}}, win_lo(std_i)};
        hi_ext   = {{PADW{1'b0}}, win_hi(std_i)};
        in_vbi_o = (line_i <= hi_ext);
        in_win_o = (line_i >= lo_ext) && (line_i <= hi_ext);
    end
endmodule

// File: rtl/vbg_decide.sv
module vbg_decide
    import vbg_pkg::*;
(
    input  vstd_e     std_i,
    input  tmode_e    mode_i,
    input  gate_ctl_t ctl_i,
    input  logic      in_vbi_i,
    input  logic      in_win_i,
    output logic      pass_o
);
    logic vbi_on;
    logic mode_ok;
    logic cgms_ovr;

    always_comb begin
        vbi_on   = std_is_prog(std_i) ? ctl_i.vbi_en_hd : ctl_i.vbi_en_sd;
        mode_ok  = (mode_i == TM_MASTER) || (mode_i == TM_SLAVE0) || ctl_i.blk_ctl_en;
        cgms_ovr = ctl_i.cgms_en && ctl_i.cgms_line && !vbi_on;
        if (!in_vbi_i)
            pass_o = 1'b1;
        else if (cgms_ovr)
            pass_o = 1'b1;
        else
            pass_o = vbi_on && mode_ok && in_win_i;
    end
endmodule

// File: rtl/vbg_fill.sv
module vbg_fill #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pass_i,
    input  logic          luma_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          luma_o,
    output logic          blank_o
);
    localparam logic [DW-1:0] BLK_Y = DW'(16) << (DW - 8);
    localparam logic [DW-1:0] BLK_C = DW'(128) << (DW - 8);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_o  <= BLK_Y;
            luma_o  <= 1'b1;
            blank_o <= 1'b1;
        end else begin
            luma_o  <= luma_i;
            blank_o <= !pass_i;
            data_o  <= pass_i ? data_i : (luma_i ? BLK_Y : BLK_C);
        end
    end

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (rst)
        pass_i |=> (!blank_o && data_o == $past(data_i))); // R11

    AST_BLANK_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !pass_i |=> (blank_o && data_o == ($past(luma_i) ? BLK_Y : BLK_C))); // R10
endmodule

// File: rtl/vbi_gate.sv
module vbi_gate
    import vbg_pkg::*;
#(
    parameter int DW     = 8,
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        std_sel,
    input  logic [1:0]        tmode,
    input  logic              vbi_en_hd,
    input  logic              vbi_en_sd,
    input  logic              blk_ctl_en,
    input  logic              cgms_en,
    input  logic              cgms_line,
    input  logic [LINE_W-1:0] line_num,
    input  logic              in_luma,
    input  logic [DW-1:0]     in_data,
    output logic [DW-1:0]     out_data,
    output logic              out_luma,
    output logic              out_blank
);
    vstd_e     std_v;
    tmode_e    mode_v;
    gate_ctl_t ctl;
    logic      in_vbi;
    logic      in_win;
    logic      pass;

    always_comb begin
        std_v  = vstd_e'(std_sel);
        mode_v = tmode_e'(tmode);
        ctl    = '{vbi_en_hd: vbi_en_hd, vbi_en_sd: vbi_en_sd,
                   blk_ctl_en: blk_ctl_en, cgms_en: cgms_en, cgms_line: cgms_line};
    end

    vbg_window #(.LINE_W(LINE_W)) u_win (
        .std_i(std_v), .line_i(line_num), .in_vbi_o(in_vbi), .in_win_o(in_win)
    );

    vbg_decide u_dec (
        .std_i(std_v), .mode_i(mode_v), .ctl_i(ctl),
        .in_vbi_i(in_vbi), .in_win_i(in_win), .pass_o(pass)
    );

    vbg_fill #(.DW(DW)) u_fill (
        .clk(clk), .rst(rst), .pass_i(pass), .luma_i(in_luma), .data_i(in_data),
        .data_o(out_data), .luma_o(out_luma), .blank_o(out_blank)
    );

    logic sel_en;
    logic ovr;
    assign sel_en = std_sel[1] ? vbi_en_sd : vbi_en_hd;
    assign ovr    = cgms_en && cgms_line && !sel_en;

    AST_ACTIVE_PASS: assert property (@(posedge clk) disable iff (rst)
        !in_vbi |=> !out_blank); // R5

    AST_DISABLED_BLANK: assert property (@(posedge clk) disable iff (rst)
        (in_vbi && !sel_en && !ovr) |=> out_blank); // R6

    AST_SLAVE12_NEEDS_CTL: assert property (@(posedge clk) disable iff (rst)
        (in_vbi && tmode[1] && !blk_ctl_en && !ovr) |=> out_blank); // R8

    AST_CGMS_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
        (in_vbi && ovr) |=> !out_blank); // R9
endmodule

// File: tb/vbi_gate_test.sv
module vbi_gate_test;
    localparam int DW = 8;
    localparam int LW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] std_sel = '0;
    logic [1:0] tmode = '0;
    logic vbi_en_hd = 1'b0, vbi_en_sd = 1'b0, blk_ctl_en = 1'b0;
    logic cgms_en = 1'b0, cgms_line = 1'b0;
    logic [LW-1:0] line_num = '0;
    logic in_luma = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [DW-1:0] out_data;
    logic out_luma, out_blank;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vbi_gate #(.DW(DW), .LINE_W(LW)) uut (
        .clk(clk), .rst(rst), .std_sel(std_sel), .tmode(tmode),
        .vbi_en_hd(vbi_en_hd), .vbi_en_sd(vbi_en_sd), .blk_ctl_en(blk_ctl_en),
        .cgms_en(cgms_en), .cgms_line(cgms_line), .line_num(line_num),
        .in_luma(in_luma), .in_data(in_data),
        .out_data(out_data), .out_luma(out_luma), .out_blank(out_blank)
    );

    typedef struct packed {
        logic [1:0] s;
        logic [1:0] m;
        logic hd, sd, bc, ce, cl;
        logic [10:0] ln;
        logic lu;
        logic [7:0] d;
        logic eb;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd12, 1'b1, 8'hA1, 1'b1, 4'd1},  // R1
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd13, 1'b1, 8'hA2, 1'b0, 4'd1},  // R1
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd42, 1'b0, 8'hA3, 1'b0, 4'd1},  // R1
        '{2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5,  1'b0, 8'hA4, 1'b1, 4'd1},  // R1
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd5,  1'b1, 8'hB1, 1'b1, 4'd2},  // R2
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd6,  1'b1, 8'hB2, 1'b0, 4'd2},  // R2
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd43, 1'b0, 8'hB3, 1'b0, 4'd2},  // R2
        '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd9,  1'b0, 8'hC1, 1'b1, 4'd3},  // R3
        '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd10, 1'b1, 8'hC2, 1'b0, 4'd3},  // R3
        '{2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20, 1'b1, 8'hC3, 1'b0, 4'd3},  // R3
        '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd6,  1'b1, 8'hD1, 1'b1, 4'd4},  // R4
        '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd7,  1'b0, 8'hD2, 1'b0, 4'd4},  // R4
        '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd22, 1'b1, 8'hD3, 1'b0, 4'd4},  // R4
        '{2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd43, 1'b1, 8'hE1, 1'b0, 4'd5},  // R5
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd44, 1'b0, 8'hE2, 1'b0, 4'd5},  // R5
        '{2'd2, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd21, 1'b1, 8'hE3, 1'b0, 4'd5},  // R5
        '{2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd262,1'b0, 8'hE4, 1'b0, 4'd5},  // R5
        '{2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd42, 1'b1, 8'h51, 1'b1, 4'd6},  // R6
        '{2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd20, 1'b0, 8'h52, 1'b1, 4'd6},  // R6
        '{2'd3, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 11'd10, 1'b1, 8'h53, 1'b1, 4'd6},  // R6
        '{2'd0, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd20, 1'b1, 8'h71, 1'b0, 4'd7},  // R7
        '{2'd3, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd15, 1'b0, 8'h72, 1'b0, 4'd7},  // R7
        '{2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd20, 1'b1, 8'h81, 1'b1, 4'd8},  // R8
        '{2'd0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 11'd20, 1'b1, 8'h82, 1'b0, 4'd8},  // R8
        '{2'd2, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd15, 1'b0, 8'h83, 1'b1, 4'd8},  // R8
        '{2'd2, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 11'd15, 1'b0, 8'h84, 1'b0, 4'd8},  // R8
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd15, 1'b1, 8'h91, 1'b0, 4'd9},  // R9
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 11'd15, 1'b1, 8'h92, 1'b1, 4'd9},  // R9
        '{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 11'd15, 1'b1, 8'h93, 1'b1, 4'd9},  // R9
        '{2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 11'd3,  1'b0, 8'h94, 1'b0, 4'd9},  // R9
        '{2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd15, 1'b1, 8'h61, 1'b1, 4'd12}, // R12
        '{2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd20, 1'b0, 8'h62, 1'b1, 4'd12}, // R12
        '{2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 11'd20, 1'b0, 8'h63, 1'b0, 4'd12}, // R12
        '{2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 11'd8,  1'b1, 8'h64, 1'b0, 4'd12}  // R12
    };

    task automatic check(input string req, input logic [DW-1:0] got_d, input logic got_b,
                         input logic [DW-1:0] exp_d, input logic exp_b);
        n_chk++;
        if (got_d !== exp_d || got_b !== exp_b) begin
            n_fail++;
            $display("FAIL %s: data=%h blank=%b expected data=%h blank=%b",
                     req, got_d, got_b, exp_d, exp_b);
        end
    endtask

    task automatic drive(input vec_t v);
        std_sel = v.s; tmode = v.m; vbi_en_hd = v.hd; vbi_en_sd = v.sd;
        blk_ctl_en = v.bc; cgms_en = v.ce; cgms_line = v.cl;
        line_num = v.ln; in_luma = v.lu; in_data = v.d;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] exp_d;
        rst = 1'b1;
        in_data = 8'hEE;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13 reset values
        check("R13", out_data, out_blank, 8'h10, 1'b1);
        check("R13 luma", {7'd0, out_luma}, 1'b0, 8'h01, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            exp_d = VEC[i].eb ? (VEC[i].lu ? 8'h10 : 8'h80) : VEC[i].d;
            check($sformatf("R%0d vec %0d", VEC[i].rq, i), out_data, out_blank, exp_d, VEC[i].eb);
        end

        // R10 blank levels for both phases back to back
        drive('{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd20, 1'b1, 8'h33, 1'b1, 4'd10});
        @(posedge clk); @(negedge clk);
        check("R10 luma level", out_data, out_blank, 8'h10, 1'b1);
        in_luma = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R10 chroma level", out_data, out_blank, 8'h80, 1'b1);

        // R11 one-clock latency with a changing stream on an active line
        drive('{2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 11'd100, 1'b1, 8'h11, 1'b0, 4'd11});
        @(posedge clk); @(negedge clk);
        check("R11 first", out_data, out_blank, 8'h11, 1'b0);
        for (int k = 0; k < 4; k++) begin
            in_data = 8'h20 + 8'(k);
            in_luma = ~in_luma;
            #1;
            check("R11 holds before edge", out_data, out_blank,
                  (k == 0) ? 8'h11 : 8'h20 + 8'(k - 1), 1'b0);
            @(posedge clk); @(negedge clk);
            check("R11 after edge", out_data, out_blank, 8'h20 + 8'(k), 1'b0);
        end

        // R13 reset applied again mid-stream
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R13 re-reset", out_data, out_blank, 8'h10, 1'b1);
        rst = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule